// File: doc/BRIEF.md
# Delta Modulation Sample Channel

This block plays a stream of 1-bit delta-encoded audio samples. Software gives it a start address and a byte length and then pulses a start strobe. The block fetches the bytes one at a time over a simple request/acknowledge DMA port into a one-byte holding buffer. A rate divider, set by a 4-bit index into sixteen preset periods, produces shift ticks. Every eighth shift tick opens a new output cycle. At that point the buffered byte is moved into an 8-bit shift register. Over the next eight shift ticks each bit, least significant first, raises or lowers a 7-bit output level by two. The level saturates at the ends of its range instead of wrapping.

A cycle that opens while the buffer is empty is a silent cycle: for all eight of its shift ticks the level does not move. The level can also be written directly through a load strobe. This gives raw 7-bit PCM playback, or sets the starting point for delta playback.

Top module: `dmc_channel`

## Requirements
- R1: After reset the output level is 0 and no DMA request is raised.
- R2: A one-clock start strobe loads the start address and byte length. On the next clock, if the buffer is empty and the length is non-zero, `dma_req` is high and `dma_addr` carries the start address.
- R3: When `dma_ack` is high while `dma_req` is high, `dma_data` is captured into the buffer and the address advances by one. The request then stays low while the buffer holds a byte.
- R4: The address advancing from 0xFFFF goes to 0x8000.
- R5: Each captured byte lowers the remaining length by one. Once it reaches zero, no further request is raised until the next start strobe.
- R6: Shift ticks come every P clocks. P is picked by `rate_sel` from the following list, given for indices 0 to 15: 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72, 54. A new output cycle opens every 8 shift ticks.
- R7: Bits of a played byte are applied LSB first, one per shift tick. A 1 adds 2 to the level and a 0 subtracts 2.
- R8: A step that would take the level above 127 or below 0 is skipped, and the level keeps its value.
- R9: If the buffer is empty when a cycle opens, the level does not change during that cycle's eight shift ticks.
- R10: A load strobe sets the level to `level_din` on the next clock, and it takes priority over a step in the same clock.
- R11: Opening a cycle with a full buffer empties it. When bytes remain, a new request for the next address follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| play_start | input | 1 | Start strobe: load address and length |
| play_addr | input | 16 | Address of the first sample byte |
| play_len | input | 12 | Number of sample bytes to fetch |
| rate_sel | input | 4 | Index of the shift-tick period |
| level_we | input | 1 | Direct level load strobe |
| level_din | input | 7 | Value for the direct level load |
| dma_req | output | 1 | Request for the next sample byte |
| dma_addr | output | 16 | Address of the requested byte |
| dma_ack | input | 1 | Data-valid acknowledge for the request |
| dma_data | input | 8 | Sample byte returned by memory |
| level | output | 7 | Output level |

## Verification
A fault in the address or length counters shows on `dma_addr` or `dma_req` at the very next request, within one output cycle of a buffer drain. A fault in the bit counter, the shift register or the silence flag shows in the level itself. It appears as a wrong first step direction, a wrong gap between steps, or a level that moves during a starved cycle, all visible within eight shift ticks. Clamping faults appear as a level outside the saturation point after one byte of all ones or all zeros.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  localparam int BYTE_W    = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W);
  localparam int RATE_W    = 4;
  localparam int PERIOD_W  = 9;

  // Shift-tick period, in clocks, for each rate index
  function automatic logic [PERIOD_W-1:0] rate_period(input logic [RATE_W-1:0] idx);
    logic [PERIOD_W-1:0] p;
    case (idx)
      4'd0:    p = 9'd428;
      4'd1:    p = 9'd380;
      4'd2:    p = 9'd340;
      4'd3:    p = 9'd320;
      4'd4:    p = 9'd286;
      4'd5:    p = 9'd254;
      4'd6:    p = 9'd226;
      4'd7:    p = 9'd214;
      4'd8:    p = 9'd190;
      4'd9:    p = 9'd160;
      4'd10:   p = 9'd142;
      4'd11:   p = 9'd128;
      4'd12:   p = 9'd106;
      4'd13:   p = 9'd84;
      4'd14:   p = 9'd72;
      default: p = 9'd54;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/dmc_rate_div.sv
module dmc_rate_div
  import dmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              shift_tick
);
  localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

  logic [PERIOD_W-1:0] cnt_q, cnt_d;

  assign shift_tick = (cnt_q == '0);

  always_comb begin
    if (shift_tick) cnt_d = rate_period(rate_sel) - ONE;
    else            cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    shift_tick |=> !shift_tick); // R6
endmodule

// File: rtl/dmc_fetch.sv
module dmc_fetch
  import dmc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int COUNT_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic [COUNT_W-1:0] start_count,
  input  logic               take,
  input  logic               dma_ack,
  input  logic [BYTE_W-1:0]  dma_data,
  output logic               dma_req,
  output logic [ADDR_W-1:0]  dma_addr,
  output logic [BYTE_W-1:0]  buf_data,
  output logic               buf_full
);
  localparam logic [ADDR_W-1:0]  ADDR_LAST = '1;
  localparam logic [ADDR_W-1:0]  WRAP_TO   = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0]  ADDR_ONE  = ADDR_W'(1);
  localparam logic [COUNT_W-1:0] CNT_ONE   = COUNT_W'(1);

  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [COUNT_W-1:0] left_q, left_d;
  logic [BYTE_W-1:0]  buf_q, buf_d;
  logic               full_q, full_d;
  logic               grab;

  assign dma_req  = !full_q && (left_q != '0);
  assign grab     = dma_req && dma_ack;
  assign dma_addr = addr_q;
  assign buf_data = buf_q;
  assign buf_full = full_q;

  always_comb begin
    addr_d = addr_q;
    left_d = left_q;
    buf_d  = buf_q;
    full_d = full_q;
    if (grab) begin
      buf_d  = dma_data;
      full_d = 1'b1;
      addr_d = (addr_q == ADDR_LAST) ? WRAP_TO : addr_q + ADDR_ONE;
      left_d = left_q - CNT_ONE;
    end
    if (take) full_d = 1'b0;
    if (start) begin
      addr_d = start_addr;
      left_d = start_count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
      buf_q  <= '0;
      full_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      left_q <= left_d;
      if (grab) buf_q <= buf_d;
      full_q <= full_d;
    end
  end

  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (grab && !start && addr_q == ADDR_LAST) |=> (dma_addr == WRAP_TO)); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (grab && !start) |=> (left_q == $past(left_q) - CNT_ONE)); // R5
  AST_IDLE_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q == '0 && !start) |=> !dma_req); // R5
  AST_HOLD_AFTER_GRAB: assert property (@(posedge clk) disable iff (!rst_n)
    grab |=> (buf_full && !dma_req)); // R3
  AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !buf_full); // R11
endmodule

// File: rtl/dmc_output.sv
module dmc_output
  import dmc_pkg::*;
#(
  parameter int LEVEL_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_tick,
  input  logic               buf_full,
  input  logic [BYTE_W-1:0]  buf_data,
  input  logic               level_we,
  input  logic [LEVEL_W-1:0] level_din,
  output logic               take,
  output logic [LEVEL_W-1:0] level
);
  localparam logic [LEVEL_W-1:0]   LVL_MAX  = '1;
  localparam logic [LEVEL_W-1:0]   STEP     = LEVEL_W'(2);
  localparam logic [BIT_CNT_W-1:0] BIT_LAST = BIT_CNT_W'(BYTE_W-1);
  localparam logic [BIT_CNT_W-1:0] BIT_ONE  = BIT_CNT_W'(1);

  logic [BYTE_W-1:0]    sh_q, sh_d;
  logic [BIT_CNT_W-1:0] bit_q, bit_d;
  logic                 silent_q, silent_d;
  logic [LEVEL_W-1:0]   lvl_q, lvl_d;
  logic                 cycle_tick;

  assign cycle_tick = shift_tick && (bit_q == '0);
  assign take       = cycle_tick && buf_full;
  assign level      = lvl_q;

  always_comb begin
    sh_d     = sh_q;
    bit_d    = bit_q;
    silent_d = silent_q;
    lvl_d    = lvl_q;
    if (shift_tick) begin
      if (!silent_q) begin
        if (sh_q[0]) begin
          if (lvl_q <= LVL_MAX - STEP) lvl_d = lvl_q + STEP;
        end else begin
          if (lvl_q >= STEP) lvl_d = lvl_q - STEP;
        end
      end
      sh_d = sh_q >> 1;
      if (bit_q == '0) begin
        bit_d = BIT_LAST;
        if (buf_full) begin
          sh_d     = buf_data;
          silent_d = 1'b0;
        end else begin
          silent_d = 1'b1;
        end
      end else begin
        bit_d = bit_q - BIT_ONE;
      end
    end
    if (level_we) lvl_d = level_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      bit_q    <= '0;
      silent_q <= 1'b1;
      lvl_q    <= '0;
    end else begin
      if (shift_tick) begin
        sh_q     <= sh_d;
        bit_q    <= bit_d;
        silent_q <= silent_d;
      end
      lvl_q <= lvl_d;
    end
  end

  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    !level_we |=> (lvl_q == $past(lvl_q) || lvl_q == $past(lvl_q) + STEP ||
                   lvl_q == $past(lvl_q) - STEP)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_we && lvl_q > LVL_MAX - STEP) |=> (lvl_q > LVL_MAX - STEP - STEP)); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_we && lvl_q < STEP) |=> (lvl_q < STEP + STEP)); // R8
  AST_SILENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (silent_q && !level_we) |=> $stable(lvl_q)); // R9
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    level_we |=> (lvl_q == $past(level_din))); // R10
endmodule

// File: rtl/dmc_channel.sv
module dmc_channel
  import dmc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int COUNT_W = 12,
  parameter int LEVEL_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               play_start,
  input  logic [ADDR_W-1:0]  play_addr,
  input  logic [COUNT_W-1:0] play_len,
  input  logic [RATE_W-1:0]  rate_sel,
  input  logic               level_we,
  input  logic [LEVEL_W-1:0] level_din,
  output logic               dma_req,
  output logic [ADDR_W-1:0]  dma_addr,
  input  logic               dma_ack,
  input  logic [BYTE_W-1:0]  dma_data,
  output logic [LEVEL_W-1:0] level
);
  logic [1:0]        rst_pipe_q;
  logic              rst_n_int;
  logic              shift_tick;
  logic              take;
  logic              buf_full;
  logic [BYTE_W-1:0] buf_data;

  // Reset asserts at once and is released two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  dmc_rate_div u_div (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .rate_sel   (rate_sel),
    .shift_tick (shift_tick)
  );

  dmc_fetch #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .start       (play_start),
    .start_addr  (play_addr),
    .start_count (play_len),
    .take        (take),
    .dma_ack     (dma_ack),
    .dma_data    (dma_data),
    .dma_req     (dma_req),
    .dma_addr    (dma_addr),
    .buf_data    (buf_data),
    .buf_full    (buf_full)
  );

  dmc_output #(.LEVEL_W(LEVEL_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .shift_tick (shift_tick),
    .buf_full   (buf_full),
    .buf_data   (buf_data),
    .level_we   (level_we),
    .level_din  (level_din),
    .take       (take),
    .level      (level)
  );
endmodule

// File: tb/tb_dmc_channel.sv
`timescale 1ns/1ps
module tb_dmc_channel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        play_start;
  logic [15:0] play_addr;
  logic [11:0] play_len;
  logic [3:0]  rate_sel;
  logic        level_we;
  logic [6:0]  level_din;
  logic        dma_req;
  logic [15:0] dma_addr;
  logic        dma_ack;
  logic [7:0]  dma_data;
  logic [6:0]  level;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dmc_channel dut (
    .clk(clk), .rst_n(rst_n), .play_start(play_start), .play_addr(play_addr),
    .play_len(play_len), .rate_sel(rate_sel), .level_we(level_we),
    .level_din(level_din), .dma_req(dma_req), .dma_addr(dma_addr),
    .dma_ack(dma_ack), .dma_data(dma_data), .level(level)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_level(input logic [6:0] v);
    level_we = 1'b1; level_din = v;
    tick(1);
    level_we = 1'b0;
  endtask

  task automatic start_play(input logic [15:0] a, input logic [11:0] n);
    play_start = 1'b1; play_addr = a; play_len = n;
    tick(1);
    play_start = 1'b0;
  endtask

  // Wait for a request, check its address, then acknowledge one byte
  task automatic serve(input logic [7:0] d, input logic [15:0] exp_addr, input string tag);
    int w = 0;
    while (!dma_req && w < 10000) begin tick(1); w++; end
    check(dma_req == 1'b1, {tag, " request"}, int'(dma_req), 1);
    check(dma_addr == exp_addr, {tag, " address"}, int'(dma_addr), int'(exp_addr));
    dma_ack = 1'b1; dma_data = d;
    tick(1);
    dma_ack = 1'b0;
  endtask

  task automatic wait_change(input int maxc, output int gap, output logic [6:0] nl);
    logic [6:0] p;
    p = level; gap = 0;
    while (level == p && gap < maxc) begin tick(1); gap++; end
    nl = level;
  endtask

  task automatic t_reset();
    check(level == 7'd0, "R1 level", int'(level), 0);
    check(dma_req == 1'b0, "R1 request", int'(dma_req), 0);
  endtask

  task automatic t_load();
    load_level(7'd64);
    check(level == 7'd64, "R10 load", int'(level), 64);
  endtask

  task automatic t_fetch();
    start_play(16'h1234, 12'd2);
    check(dma_req == 1'b1, "R2 request after start", int'(dma_req), 1);
    check(dma_addr == 16'h1234, "R2 start address", int'(dma_addr), 'h1234);
    serve(8'hFF, 16'h1234, "R3 first");
    check(dma_req == 1'b0, "R3 request low while full", int'(dma_req), 0);
    serve(8'hFF, 16'h1235, "R11 refill");
    tick(1200);
    check(level == 7'd96, "R7 two bytes of ones", int'(level), 96);
    check(dma_req == 1'b0, "R5 no request after length", int'(dma_req), 0);
  endtask

  task automatic t_order();
    int g; logic [6:0] nl;
    load_level(7'd64);
    start_play(16'h4000, 12'd1);
    serve(8'h0F, 16'h4000, "R7 byte 0F");
    wait_change(2000, g, nl);
    check(nl == 7'd66, "R7 LSB one steps up", int'(nl), 66);
    tick(1200);
    check(level == 7'd64, "R7 0F net zero", int'(level), 64);
    start_play(16'h4001, 12'd1);
    serve(8'hF0, 16'h4001, "R7 byte F0");
    wait_change(2000, g, nl);
    check(nl == 7'd62, "R7 LSB zero steps down", int'(nl), 62);
    tick(1200);
  endtask

  task automatic t_rate();
    int g; logic [6:0] nl;
    load_level(7'd20);
    rate_sel = 4'd15;
    start_play(16'h0100, 12'd1);
    serve(8'hFF, 16'h0100, "R6 fast");
    wait_change(2000, g, nl);
    wait_change(2000, g, nl);
    check(g == 54, "R6 period index 15", g, 54);
    tick(1200);
    rate_sel = 4'd0;
    load_level(7'd20);
    start_play(16'h0200, 12'd1);
    serve(8'hFF, 16'h0200, "R6 slow");
    wait_change(10000, g, nl);
    wait_change(10000, g, nl);
    check(g == 428, "R6 period index 0", g, 428);
    tick(9000);
    rate_sel = 4'd15;
    tick(600);
  endtask

  task automatic t_wrap();
    start_play(16'hFFFF, 12'd2);
    serve(8'hAA, 16'hFFFF, "R4 last address");
    serve(8'hAA, 16'h8000, "R4 wrapped address");
    tick(1200);
  endtask

  task automatic t_clamp();
    load_level(7'd124);
    start_play(16'h0300, 12'd1);
    serve(8'hFF, 16'h0300, "R8 top");
    tick(1200);
    check(level == 7'd126, "R8 top saturation", int'(level), 126);
    load_level(7'd3);
    start_play(16'h0301, 12'd1);
    serve(8'h00, 16'h0301, "R8 bottom");
    tick(1200);
    check(level == 7'd1, "R8 bottom saturation", int'(level), 1);
  endtask

  task automatic t_silence();
    int moved = 0;
    load_level(7'd50);
    start_play(16'h0400, 12'd1);
    for (int i = 0; i < 1500; i++) begin
      tick(1);
      if (level != 7'd50) moved++;
    end
    check(moved == 0, "R9 starved cycles hold level", moved, 0);
    serve(8'hFF, 16'h0400, "R9 late byte");
    tick(1200);
    check(level == 7'd66, "R9 byte after silence", int'(level), 66);
  endtask

  task automatic t_done();
    int seen = 0;
    start_play(16'h0500, 12'd2);
    serve(8'hAA, 16'h0500, "R5 byte 1");
    serve(8'hAA, 16'h0501, "R5 byte 2");
    for (int i = 0; i < 3000; i++) begin
      tick(1);
      if (dma_req) seen++;
    end
    check(seen == 0, "R5 fetching stops", seen, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; play_start = 1'b0; play_addr = '0; play_len = '0;
    rate_sel = 4'd15; level_we = 1'b0; level_din = '0; dma_ack = 1'b0; dma_data = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_load();
    t_fetch();
    t_order();
    t_rate();
    t_wrap();
    t_clamp();
    t_silence();
    t_done();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule